// File: doc/BRIEF.md
# 8b/10b Encoding Serial Transmitter

This block turns a stream of bytes into a DC-balanced serial bit stream. Each byte comes with a flag that marks it as a control character or as ordinary data. The byte is encoded into a 10-bit symbol by two sub-encoders. A 5-bit part becomes a 6-bit sub-block, and a 3-bit part becomes a 4-bit sub-block. Each sub-encoder picks between complementary codewords according to the running disparity that reaches it. A ten-stage ring shifter then sends the symbol one bit per clock. The line rate is therefore ten bits per byte, which is 25% above the payload rate.

A free-running bit counter starts at reset and defines a load slot on every tenth clock. The sender presents a byte at that slot. The new symbol is captured on the same edge that ends the last bit of the previous symbol, so the line has no gap bits. If no valid byte is present at a slot, the comma K28.5 is sent as idle. A control flag on a byte that is not one of the twelve legal control characters raises an error output. That byte is then encoded as data.

Top module: `ser8b10b_tx`

## Requirements
- R1: Each symbol occupies exactly ten consecutive clocks with no gap. Its bits leave in the order a,b,c,d,e,i,f,g,h,j, where a to i is the 6-bit sub-block and f to j the 4-bit sub-block. The first bit appears on the cycle after its load edge.
- R2: Data bytes map to the standard codewords, with the byte split as HGF/EDCBA. D21.5 (0xB5) gives 1010101010. D0.0 gives 1001110100 at negative disparity and 0110001011 at positive. D7.0 gives 1110001011 at negative and 0001110100 at positive.
- R3: `rd_pos` shows the running disparity after the last loaded symbol: 0 means negative, 1 means positive. It changes only at a load edge. It flips exactly when the loaded symbol has nonzero disparity.
- R4: Every symbol has disparity 0, +2 or -2. It is never +2 when entered at positive disparity, and never -2 when entered at negative disparity.
- R5: No run of identical bits on the line is longer than five, across symbol boundaries included.
- R6: Twelve control bytes are legal with `is_ctrl`=1: 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC (K28.0 to K28.7), 0xF7, 0xFB, 0xFD and 0xFE. Any other byte with `is_ctrl`=1 sets `code_err` for the whole duration of its symbol and is encoded as the data byte of the same value. Data bytes never set `code_err`.
- R7: Within one symbol, a run of five identical bits occurs for K28.1, K28.5 and K28.7 and for no other code. K28.5 is 0011111010 at negative disparity and 1100000101 at positive. K28.1 at negative disparity is 0011111001, and K28.7 is 0011111000.
- R8: When `din_valid` is low at a load edge, the idle comma K28.5 is sent.
- R9: `din`, `is_ctrl` and `din_valid` are sampled only at a load edge, which is the tenth rising edge after reset is released and every tenth edge after that. A strobe at any other edge has no effect.
- R10: While in reset, and for the first ten clocks after reset is released, the line carries the neutral pattern 1010101010. During that time `rd_pos`=0 and `code_err`=0.
- R11: For D.x.7 the alternate 4-bit code is used in two cases: x = 17, 18 or 20 at negative disparity, and x = 11, 13 or 14 at positive disparity. D17.7 at negative disparity is 1000110111, and D11.7 at positive disparity is 1101001000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Byte to encode, HGFEDCBA |
| is_ctrl | input | 1 | Byte is a control character |
| din_valid | input | 1 | Byte is present at this load slot |
| sdo | output | 1 | Serial line bit |
| rd_pos | output | 1 | Running disparity, 1 = positive |
| code_err | output | 1 | Illegal control byte in the symbol now being sent |

## Verification
The hardest cases to reach are the D.x.7 alternates and the disparity-dependent goldens. They need a given running disparity at the exact load slot, and that disparity depends on the whole history of the stream. The stimulus reads `rd_pos` and inserts idle K28.5 symbols, each of which flips the disparity, until the wanted value is reached. It then loads the byte under test. Off-slot strobes are driven mid-symbol with an illegal control byte. If that strobe were sampled, it would show up as an error flag or as a non-idle symbol.

// File: rtl/ser8b10b_pkg.sv
package ser8b10b_pkg;
   localparam int BYTE_BITS = 8;
   localparam int SYM_BITS  = 10;
   typedef logic [4:0] x_t;
   typedef logic [2:0] y_t;

   // the twelve control characters accepted by the encoder
   function automatic logic ctrl_legal(input x_t x, input y_t y);
      return (x == 5'd28) ||
             ((y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
   endfunction

   // D.x.7 alternate 4b code selection, rd = disparity at the 4b point
   function automatic logic use_alt7(input x_t x, input logic rd);
      return rd ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                : (x == 5'd17 || x == 5'd18 || x == 5'd20);
   endfunction
endpackage

// File: rtl/ser8b10b_enc6.sv
module ser8b10b_enc6
   import ser8b10b_pkg::*;
(
   input  x_t         x,
   input  logic       k28,
   input  logic       rd_in,
   output logic [5:0] code,
   output logic       rd_out
);
   logic [5:0] base;
   logic       neutral;
   logic       flip;

   always_comb begin
      unique case (x)
         5'd0:  base = 6'b100111;  5'd1:  base = 6'b011101;
         5'd2:  base = 6'b101101;  5'd3:  base = 6'b110001;
         5'd4:  base = 6'b110101;  5'd5:  base = 6'b101001;
         5'd6:  base = 6'b011001;  5'd7:  base = 6'b111000;
         5'd8:  base = 6'b111001;  5'd9:  base = 6'b100101;
         5'd10: base = 6'b010101;  5'd11: base = 6'b110100;
         5'd12: base = 6'b001101;  5'd13: base = 6'b101100;
         5'd14: base = 6'b011100;  5'd15: base = 6'b010111;
         5'd16: base = 6'b011011;  5'd17: base = 6'b100011;
         5'd18: base = 6'b010011;  5'd19: base = 6'b110010;
         5'd20: base = 6'b001011;  5'd21: base = 6'b101010;
         5'd22: base = 6'b011010;  5'd23: base = 6'b111010;
         5'd24: base = 6'b110011;  5'd25: base = 6'b100110;
         5'd26: base = 6'b010110;  5'd27: base = 6'b110110;
         5'd28: base = 6'b001110;  5'd29: base = 6'b101110;
         5'd30: base = 6'b011110;  default: base = 6'b101011;
      endcase
      if (k28) base = 6'b001111;
      neutral = ($countones(base) == 3);
      flip    = !neutral || (x == 5'd7 && !k28);
      code    = (rd_in && flip) ? ~base : base;
      rd_out  = neutral ? rd_in : ~rd_in;
   end
endmodule

// File: rtl/ser8b10b_enc4.sv
module ser8b10b_enc4
   import ser8b10b_pkg::*;
(
   input  y_t         y,
   input  x_t         x,
   input  logic       kmode,
   input  logic       rd_in,
   output logic [3:0] code,
   output logic       rd_out
);
   logic [3:0] base;
   logic       neutral;
   logic       flip;

   always_comb begin
      if (kmode) begin
         unique case (y)
            3'd0: base = 4'b1011;  3'd1: base = 4'b0110;
            3'd2: base = 4'b1010;  3'd3: base = 4'b1100;
            3'd4: base = 4'b1101;  3'd5: base = 4'b0101;
            3'd6: base = 4'b1001;  default: base = 4'b0111;
         endcase
      end else begin
         unique case (y)
            3'd0: base = 4'b1011;  3'd1: base = 4'b1001;
            3'd2: base = 4'b0101;  3'd3: base = 4'b1100;
            3'd4: base = 4'b1101;  3'd5: base = 4'b1010;
            3'd6: base = 4'b0110;
            default: base = use_alt7(x, rd_in) ? 4'b0111 : 4'b1110;
         endcase
      end
      neutral = ($countones(base) == 2);
      flip    = kmode || !neutral || (y == 3'd3);
      code    = (rd_in && flip) ? ~base : base;
      rd_out  = neutral ? rd_in : ~rd_in;
   end
endmodule

// File: rtl/ser8b10b_shift.sv
module ser8b10b_shift #(
   parameter int                SYM_W    = 10,
   parameter bit                A_FIRST  = 1'b1,
   parameter logic [SYM_W-1:0]  PREAMBLE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] sym_in,
   output logic             load,
   output logic             sdo
);
   localparam int CNT_W = $clog2(SYM_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

   logic [CNT_W-1:0] cnt;
   logic [SYM_W-1:0] ring;

   assign load = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   generate
      if (A_FIRST) begin : g_msb_out
         always_ff @(posedge clk) begin
            if (!rst_n)    ring <= PREAMBLE;
            else if (load) ring <= sym_in;
            else           ring <= {ring[SYM_W-2:0], ring[SYM_W-1]};
         end
         assign sdo = ring[SYM_W-1];
      end else begin : g_lsb_out
         always_ff @(posedge clk) begin
            if (!rst_n)    ring <= PREAMBLE;
            else if (load) ring <= sym_in;
            else           ring <= {ring[0], ring[SYM_W-1:1]};
         end
         assign sdo = ring[0];
      end
   endgenerate
endmodule

// File: rtl/ser8b10b_tx.sv
module ser8b10b_tx
   import ser8b10b_pkg::*;
#(
   parameter int               BYTE_W    = 8,
   parameter int               SYM_W     = 10,
   parameter logic [7:0]       IDLE_CODE = 8'hBC,
   parameter bit               A_FIRST   = 1'b1,
   parameter logic [SYM_W-1:0] PREAMBLE  = 10'b1010101010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] din,
   input  logic              is_ctrl,
   input  logic              din_valid,
   output logic              sdo,
   output logic              rd_pos,
   output logic              code_err
);
   generate
      if (BYTE_W != BYTE_BITS || SYM_W != SYM_BITS) begin : g_bad_width
         $error("ser8b10b_tx: byte and symbol widths are fixed at 8 and 10");
      end
      if (IDLE_CODE[4:0] != 5'd28) begin : g_bad_idle
         $error("ser8b10b_tx: idle code must be a K28 comma");
      end
   endgenerate

   logic [BYTE_W-1:0] sel_byte;
   logic              sel_k, legal_k;
   x_t                x;
   y_t                y;
   logic [5:0]        c6;
   logic [3:0]        c4;
   logic              rd_q, rd_mid, rd_end, err_q, load;

   assign sel_byte = din_valid ? din : IDLE_CODE;
   assign sel_k    = din_valid ? is_ctrl : 1'b1;
   assign x        = sel_byte[4:0];
   assign y        = sel_byte[7:5];
   assign legal_k  = sel_k && ctrl_legal(x, y);

   ser8b10b_enc6 u_enc6 (
      .x(x), .k28(legal_k && x == 5'd28), .rd_in(rd_q), .code(c6), .rd_out(rd_mid)
   );
   ser8b10b_enc4 u_enc4 (
      .y(y), .x(x), .kmode(legal_k), .rd_in(rd_mid), .code(c4), .rd_out(rd_end)
   );
   ser8b10b_shift #(.SYM_W(SYM_W), .A_FIRST(A_FIRST), .PREAMBLE(PREAMBLE)) u_shift (
      .clk(clk), .rst_n(rst_n), .sym_in({c6, c4}), .load(load), .sdo(sdo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         err_q <= 1'b0;
      end else if (load) begin
         rd_q  <= rd_end;
         err_q <= sel_k && !legal_k;
      end
   end

   assign rd_pos   = rd_q;
   assign code_err = err_q;
endmodule

// File: rtl/ser8b10b_tx_chk.sv
module ser8b10b_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic din_valid,
   input logic is_ctrl,
   input logic sdo,
   input logic rd_pos,
   input logic code_err
);
   logic [3:0] phase;
   logic [3:0] run_q, run_now;
   logic       prev_q;

   assign run_now = (sdo == prev_q) ? ((run_q == 4'hF) ? run_q : run_q + 4'd1) : 4'd1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= '0;
         run_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         phase  <= (phase == 4'd9) ? 4'd0 : phase + 4'd1;
         run_q  <= run_now;
         prev_q <= sdo;
      end
   end

   // R3 and R6: disparity and error flag move only at a load edge
   p_hold_between_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != 4'd9) |=> ($stable(rd_pos) && $stable(code_err)));

   // R5: line run length limit
   p_run_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run_now <= 4'd5);

   // R6: only a flagged control byte can raise the error
   p_err_needs_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 4'd9 && !(din_valid && is_ctrl)) |=> !code_err);

   // R8: idle comma starts with the bit equal to the disparity it was entered at
   p_idle_comma_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 4'd9 && !din_valid) |=> (sdo == $past(rd_pos)));
endmodule

bind ser8b10b_tx ser8b10b_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .is_ctrl(is_ctrl),
   .sdo(sdo), .rd_pos(rd_pos), .code_err(code_err)
);

// File: tb/ser8b10b_tx_tb.sv
module ser8b10b_tx_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] din = 8'h00;
   logic       is_ctrl = 1'b0;
   logic       din_valid = 1'b0;
   logic       sdo, rd_pos, code_err;

   int  vectors = 0;
   int  fails = 0;
   bit  done = 1'b0;
   logic model_rd = 1'b0;
   logic last_bit = 1'b0;
   int  run_len = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser8b10b_tx u_dut (
      .clk(clk), .rst_n(rst_n), .din(din), .is_ctrl(is_ctrl), .din_valid(din_valid),
      .sdo(sdo), .rd_pos(rd_pos), .code_err(code_err)
   );

   task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic bit has_run5(input logic [9:0] s);
      for (int i = 0; i <= 5; i++)
         if (s[i +: 5] == 5'b11111 || s[i +: 5] == 5'b00000) return 1'b1;
      return 1'b0;
   endfunction

   // one load slot: present stimulus, capture the symbol now on the line
   task automatic slot(input logic [7:0] b, input logic k, input logic v, input bit glitch,
                       output logic [9:0] cap, output logic e);
      logic rds, e_moved, exp_rd;
      int   d;
      rds = rd_pos;
      e = code_err;
      e_moved = 1'b0;
      din = b; is_ctrl = k; din_valid = v;
      for (int i = 0; i < 10; i++) begin
         if (glitch && i == 3) begin din = 8'h00; is_ctrl = 1'b1; din_valid = 1'b1; end
         if (glitch && i == 4) begin din_valid = 1'b0; is_ctrl = 1'b0; end
         cap[9-i] = sdo;
         if (code_err !== e) e_moved = 1'b1;
         if (sdo == last_bit) run_len++; else run_len = 1;
         last_bit = sdo;
         @(negedge clk);
      end
      d = 2 * $countones(cap) - 10;
      chk((model_rd == 1'b0) ? (d == 0 || d == 2) : (d == 0 || d == -2),
          "R4 symbol disparity", cap, {9'd0, model_rd});
      exp_rd = (d > 0) ? 1'b1 : (d < 0) ? 1'b0 : model_rd;
      chk(rds === exp_rd, "R3 running disparity", {9'd0, rds}, {9'd0, exp_rd});
      model_rd = exp_rd;
      chk(run_len <= 5, "R5 run length", 10'(run_len), 10'd5);
      chk(!e_moved, "R6 error held over symbol", {9'd0, e_moved}, 10'd0);
   endtask

   task automatic xmit(input logic [7:0] b, input logic k, output logic [9:0] s, output logic e);
      logic [9:0] junk;
      logic je;
      slot(b, k, 1'b1, 1'b0, junk, je);
      slot(8'h00, 1'b0, 1'b0, 1'b0, s, e);
   endtask

   task automatic force_rd(input logic want);
      logic [9:0] junk;
      logic je;
      for (int n = 0; n < 4 && rd_pos !== want; n++) slot(8'h00, 1'b0, 1'b0, 1'b0, junk, je);
   endtask

   task automatic golden(input logic [7:0] b, input logic k, input logic r,
                         input logic [9:0] exp, input string req);
      logic [9:0] s;
      logic e;
      force_rd(r);
      xmit(b, k, s, e);
      chk(s === exp, req, s, exp);
   endtask

   task automatic t_reset;
      logic [9:0] s;
      logic e;
      chk(rd_pos === 1'b0 && code_err === 1'b0, "R10 reset outputs", {8'd0, rd_pos, code_err}, 10'd0);
      slot(8'h00, 1'b0, 1'b0, 1'b0, s, e);
      chk(s === 10'b1010101010, "R10 preamble", s, 10'b1010101010);
      chk(e === 1'b0, "R10 error clear", {9'd0, e}, 10'd0);
   endtask

   task automatic t_data_golden;
      golden(8'hB5, 1'b0, 1'b0, 10'b1010101010, "R1 R2 D21.5 neg");
      golden(8'hB5, 1'b0, 1'b1, 10'b1010101010, "R2 D21.5 pos");
      golden(8'h00, 1'b0, 1'b0, 10'b1001110100, "R1 R2 D0.0 neg");
      golden(8'h00, 1'b0, 1'b1, 10'b0110001011, "R2 D0.0 pos");
      golden(8'h07, 1'b0, 1'b0, 10'b1110001011, "R2 D7.0 neg");
      golden(8'h07, 1'b0, 1'b1, 10'b0001110100, "R2 D7.0 pos");
   endtask

   task automatic t_alt7;
      golden(8'hF1, 1'b0, 1'b0, 10'b1000110111, "R11 D17.7 neg");
      golden(8'hEB, 1'b0, 1'b1, 10'b1101001000, "R11 D11.7 pos");
   endtask

   task automatic t_commas;
      golden(8'hBC, 1'b1, 1'b0, 10'b0011111010, "R7 K28.5 neg");
      golden(8'hBC, 1'b1, 1'b1, 10'b1100000101, "R7 K28.5 pos");
      golden(8'h3C, 1'b1, 1'b0, 10'b0011111001, "R7 K28.1 neg");
      golden(8'hFC, 1'b1, 1'b0, 10'b0011111000, "R7 K28.7 neg");
   endtask

   task automatic t_ctrl_all;
      logic [7:0] kset [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
      logic [9:0] s;
      logic e;
      for (int i = 0; i < 12; i++) begin
         for (int r = 0; r < 2; r++) begin
            force_rd(r[0]);
            xmit(kset[i], 1'b1, s, e);
            chk(e === 1'b0, "R6 legal control no error", {9'd0, e}, 10'd0);
            chk(has_run5(s) == (kset[i] == 8'h3C || kset[i] == 8'hBC || kset[i] == 8'hFC),
                "R7 comma run of five", s, {2'd0, kset[i]});
         end
      end
   endtask

   task automatic t_data_sweep;
      logic [9:0] s;
      logic e;
      for (int b = 0; b < 256; b++) begin
         xmit(8'(b), 1'b0, s, e);
         chk(e === 1'b0, "R6 data no error", {9'd0, e}, 10'd0);
         chk(!has_run5(s), "R7 data has no five-run", s, 10'(b));
      end
   endtask

   task automatic t_bad_ctrl;
      logic [7:0] bad [5] = '{8'h00, 8'h1B, 8'h3B, 8'hE7, 8'hFF};
      logic [9:0] sk, sd;
      logic ek, ed;
      for (int i = 0; i < 5; i++) begin
         force_rd(1'b0);
         xmit(bad[i], 1'b1, sk, ek);
         force_rd(1'b0);
         xmit(bad[i], 1'b0, sd, ed);
         chk(ek === 1'b1, "R6 illegal control flagged", {9'd0, ek}, 10'd1);
         chk(sk === sd, "R6 illegal control coded as data", sk, sd);
      end
   endtask

   task automatic t_idle;
      logic [9:0] s, junk;
      logic e, je, r;
      force_rd(1'b1);
      r = rd_pos;
      slot(8'h55, 1'b0, 1'b0, 1'b0, junk, je);
      slot(8'h00, 1'b0, 1'b0, 1'b0, s, e);
      chk(s === (r ? 10'b1100000101 : 10'b0011111010), "R8 idle comma", s, 10'b1100000101);
   endtask

   task automatic t_offslot;
      logic [9:0] s, junk;
      logic e, je, r;
      force_rd(1'b0);
      r = rd_pos;
      slot(8'h00, 1'b0, 1'b0, 1'b1, junk, je);
      slot(8'h00, 1'b0, 1'b0, 1'b0, s, e);
      chk(s === 10'b0011111010 && r === 1'b0, "R9 off-slot strobe ignored", s, 10'b0011111010);
      chk(e === 1'b0, "R9 off-slot strobe no error", {9'd0, e}, 10'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data_golden();
      t_alt7();
      t_commas();
      t_ctrl_all();
      t_bad_ctrl();
      t_idle();
      t_offslot();
      t_data_sweep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog expired actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule